// File: doc/BRIEF.md
# Completion Interrupt Coalescing Unit

This block belongs to one request queue. It counts the finished requests that asked to be announced and decides when the queue's completion interrupt goes up. It does not raise one interrupt per completion. Instead, it holds the interrupt back until one of two things happens: enough announced results have built up, or a hold-off time has passed since the count last became nonzero or was last acknowledged. Software clears the interrupt by writing an acknowledge amount. That amount is taken off the count.

The hold-off limit is given in coarse units. Each unit is 2^TIME_SHIFT clock cycles, and the default of 10 makes each unit 1024 cycles. An acknowledge restarts the hold-off timer. The interrupt condition is then evaluated again straight away, so an interrupt that stays justified after a partial acknowledge stays high. A direct load of the count, meant for diagnostics, also restarts the timer. The enable only masks the interrupt line. Counting and timing go on while it is clear.

Top module: `cmpl_coalesce`

## Requirements
- R1: After reset the pending count is 0, the interrupt enable is clear and `irq_o` is low.
- R2: A cycle with `cpl_valid_i` and `cpl_notify_i` both high adds one to the pending count. A completion with `cpl_notify_i` low leaves the count unchanged.
- R3: An acknowledge write subtracts `ack_amt_i` from the count. If the amount exceeds the count, the count becomes 0 and does not wrap.
- R4: A counted completion and an acknowledge in the same cycle are both applied: new count = old + 1 − amount, floored at 0.
- R5: The interrupt condition holds when the count is at least `num_thresh_i`. A `num_thresh_i` of 0 acts as 1.
- R6: While the count is nonzero, the timer advances once per cycle. The condition holds once the timer reaches `time_thresh_i`·2^TIME_SHIFT, which is the 8th clock edge after the first count edge when `time_thresh_i`=2 and TIME_SHIFT=2. A `time_thresh_i` of 0 disables the time condition.
- R7: While the count is 0, the timer is held at 0 and `irq_o` is low.
- R8: An acknowledge write (any amount, including 0) or a direct count load restarts the timer from 0. The condition is re-evaluated immediately, so `irq_o` stays high after a partial acknowledge when the remaining count still meets `num_thresh_i`.
- R9: `irq_o` is high only while the enable is set. `irq_en_set_i` sets the enable, `irq_en_clr_i` clears it, and set wins when both are high.
- R10: The timer saturates at its maximum value instead of wrapping, so a time-triggered interrupt stays high.
- R11: A direct load (`cnt_we_i`) replaces the count with `cnt_wdata_i` and takes priority over a completion or acknowledge in the same cycle.
- R12: `irq_o` is registered. It changes on the same clock edge as the count and enable it reflects, and it stays level while the condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpl_valid_i | input | 1 | A request finished this cycle |
| cpl_notify_i | input | 1 | The finished request asked to be announced |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_amt_i | input | CNT_W | Amount to subtract from the count |
| cnt_we_i | input | 1 | Direct count load strobe (diagnostic) |
| cnt_wdata_i | input | CNT_W | Value for the direct load |
| irq_en_set_i | input | 1 | Set the interrupt enable |
| irq_en_clr_i | input | 1 | Clear the interrupt enable |
| num_thresh_i | input | NUM_W | Count threshold |
| time_thresh_i | input | TIME_W | Hold-off threshold in units of 2^TIME_SHIFT cycles |
| irq_o | output | 1 | Completion interrupt, level |
| pend_cnt_o | output | CNT_W | Current pending count (acknowledge read value) |

## Verification
The bench builds the block with CNT_W=6, NUM_W=6, TIME_W=4 and TIME_SHIFT=2. With a unit of four cycles, a hold-off limit can be reached in a handful of cycles. With a 6-bit timer, the saturation point is 63 cycles, which a short run passes, so the no-wrap behaviour is actually exercised. The 6-bit count keeps the floor-at-zero and same-cycle update cases easy to set up with small acknowledge amounts.

// File: rtl/cmpl_coalesce_pkg.sv
package cmpl_coalesce_pkg;

    typedef struct packed {
        logic en;
        logic irq;
    } irq_state_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cmpl_count.sv
module cmpl_count #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             ack_we_i,
    input  logic [CNT_W-1:0] ack_amt_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic [CNT_W-1:0] cnt_q_o
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {1'b0, cnt_q} + SUM_W'(inc_i);
        if (sum[CNT_W]) begin
            sum = {1'b0, {CNT_W{1'b1}}};
        end
        if (ack_we_i) begin
            if (sum >= {1'b0, ack_amt_i}) begin
                sum = sum - {1'b0, ack_amt_i};
            end else begin
                sum = '0;
            end
        end
        cnt_d = sum[CNT_W-1:0];
        if (load_i) begin
            cnt_d = load_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_d_o = cnt_d;
    assign cnt_q_o = cnt_q;

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ack_we_i && !load_i && cnt_q != {CNT_W{1'b1}})
        |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    p_ack_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we_i && !load_i && !inc_i && ack_amt_i > cnt_q) |=> cnt_q == '0);

    p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/cmpl_holdoff.sv
module cmpl_holdoff #(
    parameter int TMR_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             restart_i,
    output logic [TMR_W-1:0] tmr_d_o,
    output logic [TMR_W-1:0] tmr_q_o
);
    localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

    logic [TMR_W-1:0] tmr_d, tmr_q;

    always_comb begin
        if (!active_i || restart_i) begin
            tmr_d = '0;
        end else if (tmr_q == TMR_MAX) begin
            tmr_d = TMR_MAX;
        end else begin
            tmr_d = tmr_q + TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tmr_d_o = tmr_d;
    assign tmr_q_o = tmr_q;

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> tmr_q == '0);

    p_tmr_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q == TMR_MAX && active_i && !restart_i) |=> tmr_q == TMR_MAX);
endmodule

// File: rtl/cmpl_irq_gen.sv
module cmpl_irq_gen
    import cmpl_coalesce_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int NUM_W      = 20,
    parameter int TIME_W     = 16,
    parameter int TIME_SHIFT = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           cnt_d_i,
    input  logic [TIME_W+TIME_SHIFT-1:0] tmr_d_i,
    input  logic [NUM_W-1:0]           num_thresh_i,
    input  logic [TIME_W-1:0]          time_thresh_i,
    input  logic                       en_set_i,
    input  logic                       en_clr_i,
    output logic                       en_o,
    output logic                       irq_o
);
    localparam int TMR_W = TIME_W + TIME_SHIFT;
    localparam int CMP_W = max_int(CNT_W, NUM_W);

    irq_state_t st_d, st_q;
    logic [CMP_W-1:0] num_eff;
    logic [TMR_W-1:0] time_limit;
    logic             hit_num, hit_time;

    always_comb begin
        num_eff    = (num_thresh_i == '0) ? CMP_W'(1) : CMP_W'(num_thresh_i);
        time_limit = {time_thresh_i, {TIME_SHIFT{1'b0}}};
        hit_num    = CMP_W'(cnt_d_i) >= num_eff;
        hit_time   = (time_thresh_i != '0) && (tmr_d_i >= time_limit);

        st_d = st_q;
        if (en_set_i)      st_d.en = 1'b1;
        else if (en_clr_i) st_d.en = 1'b0;
        st_d.irq = st_d.en && (cnt_d_i != '0) && (hit_num || hit_time);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign irq_o = st_q.irq;

    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> st_q.en);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en_set_i |=> st_q.en);
endmodule

// File: rtl/cmpl_coalesce.sv
module cmpl_coalesce #(
    parameter int CNT_W      = 20,
    parameter int NUM_W      = 20,
    parameter int TIME_W     = 16,
    parameter int TIME_SHIFT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpl_valid_i,
    input  logic              cpl_notify_i,
    input  logic              ack_we_i,
    input  logic [CNT_W-1:0]  ack_amt_i,
    input  logic              cnt_we_i,
    input  logic [CNT_W-1:0]  cnt_wdata_i,
    input  logic              irq_en_set_i,
    input  logic              irq_en_clr_i,
    input  logic [NUM_W-1:0]  num_thresh_i,
    input  logic [TIME_W-1:0] time_thresh_i,
    output logic              irq_o,
    output logic [CNT_W-1:0]  pend_cnt_o
);
    localparam int TMR_W = TIME_W + TIME_SHIFT;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [TMR_W-1:0] tmr_d, tmr_q;
    logic             en_q;
    logic             inc, restart;

    assign inc     = cpl_valid_i && cpl_notify_i;
    assign restart = ack_we_i || cnt_we_i;

    cmpl_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (inc),
        .ack_we_i   (ack_we_i),
        .ack_amt_i  (ack_amt_i),
        .load_i     (cnt_we_i),
        .load_val_i (cnt_wdata_i),
        .cnt_d_o    (cnt_d),
        .cnt_q_o    (cnt_q)
    );

    cmpl_holdoff #(.TMR_W(TMR_W)) u_holdoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (cnt_q != '0),
        .restart_i (restart),
        .tmr_d_o   (tmr_d),
        .tmr_q_o   (tmr_q)
    );

    cmpl_irq_gen #(
        .CNT_W      (CNT_W),
        .NUM_W      (NUM_W),
        .TIME_W     (TIME_W),
        .TIME_SHIFT (TIME_SHIFT)
    ) u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cnt_d_i       (cnt_d),
        .tmr_d_i       (tmr_d),
        .num_thresh_i  (num_thresh_i),
        .time_thresh_i (time_thresh_i),
        .en_set_i      (irq_en_set_i),
        .en_clr_i      (irq_en_clr_i),
        .en_o          (en_q),
        .irq_o         (irq_o)
    );

    assign pend_cnt_o = cnt_q;

    p_idle_timer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == '0 |-> tmr_q == '0);

    p_irq_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> cnt_q != '0);

    p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !irq_o);
endmodule

// File: tb/cmpl_coalesce_bench.sv
module cmpl_coalesce_bench;
    localparam int CNT_W = 6;
    localparam int NUM_W = 6;
    localparam int TIME_W = 4;
    localparam int TIME_SHIFT = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpl_valid_i = 1'b0, cpl_notify_i = 1'b0;
    logic              ack_we_i = 1'b0, cnt_we_i = 1'b0;
    logic [CNT_W-1:0]  ack_amt_i = '0, cnt_wdata_i = '0;
    logic              irq_en_set_i = 1'b0, irq_en_clr_i = 1'b0;
    logic [NUM_W-1:0]  num_thresh_i = '0;
    logic [TIME_W-1:0] time_thresh_i = '0;
    logic              irq_o;
    logic [CNT_W-1:0]  pend_cnt_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    cmpl_coalesce #(
        .CNT_W(CNT_W), .NUM_W(NUM_W), .TIME_W(TIME_W), .TIME_SHIFT(TIME_SHIFT)
    ) u_cmpl_coalesce (
        .clk(clk), .rst_n(rst_n),
        .cpl_valid_i(cpl_valid_i), .cpl_notify_i(cpl_notify_i),
        .ack_we_i(ack_we_i), .ack_amt_i(ack_amt_i),
        .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
        .irq_en_set_i(irq_en_set_i), .irq_en_clr_i(irq_en_clr_i),
        .num_thresh_i(num_thresh_i), .time_thresh_i(time_thresh_i),
        .irq_o(irq_o), .pend_cnt_o(pend_cnt_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic complete(input logic notify);
        cpl_valid_i = 1'b1; cpl_notify_i = notify;
        step(1);
        cpl_valid_i = 1'b0; cpl_notify_i = 1'b0;
    endtask

    task automatic ack(input int amt);
        ack_we_i = 1'b1; ack_amt_i = CNT_W'(amt);
        step(1);
        ack_we_i = 1'b0; ack_amt_i = '0;
    endtask

    task automatic load(input int val);
        cnt_we_i = 1'b1; cnt_wdata_i = CNT_W'(val);
        step(1);
        cnt_we_i = 1'b0; cnt_wdata_i = '0;
    endtask

    task automatic en_pulse(input logic set, input logic clr);
        irq_en_set_i = set; irq_en_clr_i = clr;
        step(1);
        irq_en_set_i = 1'b0; irq_en_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 count", int'(pend_cnt_o), 0);
        check("R1 irq", int'(irq_o), 0);
        num_thresh_i = 6'd1;
        complete(1'b1);
        check("R1 enable clear irq", int'(irq_o), 0);
        ack(1);
    endtask

    task automatic t_count_threshold();
        en_pulse(1'b1, 1'b0);
        num_thresh_i = 6'd3; time_thresh_i = '0;
        complete(1'b0);
        check("R2 no notify", int'(pend_cnt_o), 0);
        complete(1'b1); complete(1'b1);
        check("R2 count", int'(pend_cnt_o), 2);
        check("R5 below threshold", int'(irq_o), 0);
        complete(1'b1);
        check("R5 count", int'(pend_cnt_o), 3);
        check("R12 irq with count edge", int'(irq_o), 1);
        step(5);
        check("R12 level", int'(irq_o), 1);
        ack(5);
        check("R3 floor", int'(pend_cnt_o), 0);
        check("R7 irq low at zero", int'(irq_o), 0);
    endtask

    task automatic t_num_zero();
        num_thresh_i = '0;
        complete(1'b1);
        check("R5 zero acts as one", int'(irq_o), 1);
        ack(1);
        check("R3 ack to zero", int'(pend_cnt_o), 0);
    endtask

    task automatic t_same_cycle();
        num_thresh_i = 6'd20;
        complete(1'b1); complete(1'b1); complete(1'b1);
        cpl_valid_i = 1'b1; cpl_notify_i = 1'b1; ack_we_i = 1'b1; ack_amt_i = 6'd2;
        step(1);
        cpl_valid_i = 1'b0; cpl_notify_i = 1'b0; ack_we_i = 1'b0; ack_amt_i = '0;
        check("R4 inc and ack", int'(pend_cnt_o), 2);
        cpl_valid_i = 1'b1; cpl_notify_i = 1'b1; ack_we_i = 1'b1; ack_amt_i = 6'd9;
        step(1);
        cpl_valid_i = 1'b0; cpl_notify_i = 1'b0; ack_we_i = 1'b0; ack_amt_i = '0;
        check("R4 floor", int'(pend_cnt_o), 0);
    endtask

    task automatic t_partial_ack();
        num_thresh_i = 6'd2;
        complete(1'b1); complete(1'b1); complete(1'b1);
        check("R5 irq at 3", int'(irq_o), 1);
        ack(1);
        check("R3 partial", int'(pend_cnt_o), 2);
        check("R8 stays high", int'(irq_o), 1);
        ack(1);
        check("R8 drops below", int'(irq_o), 0);
        ack(1);
    endtask

    task automatic t_timer();
        num_thresh_i = 6'd20; time_thresh_i = 4'd2;
        complete(1'b1);
        step(7);
        check("R6 before limit", int'(irq_o), 0);
        step(1);
        check("R6 at limit", int'(irq_o), 1);
        ack(0);
        check("R8 restart drops", int'(irq_o), 0);
        check("R8 count kept", int'(pend_cnt_o), 1);
        step(7);
        check("R8 before limit again", int'(irq_o), 0);
        step(1);
        check("R8 limit again", int'(irq_o), 1);
        step(3);
        load(1);
        check("R11 load restarts", int'(irq_o), 0);
        ack(1);
        time_thresh_i = '0;
        complete(1'b1);
        step(80);
        check("R6 zero disables", int'(irq_o), 0);
        ack(1);
    endtask

    task automatic t_saturate();
        num_thresh_i = 6'd20; time_thresh_i = 4'd15;
        complete(1'b1);
        step(59);
        check("R10 before 60", int'(irq_o), 0);
        step(1);
        check("R10 at 60", int'(irq_o), 1);
        step(100);
        check("R10 no wrap", int'(irq_o), 1);
        ack(1);
        check("R7 zero", int'(irq_o), 0);
        time_thresh_i = '0;
    endtask

    task automatic t_enable();
        num_thresh_i = 6'd1;
        en_pulse(1'b0, 1'b1);
        complete(1'b1);
        step(3);
        check("R9 masked", int'(irq_o), 0);
        check("R9 count continues", int'(pend_cnt_o), 1);
        en_pulse(1'b1, 1'b0);
        check("R9 set", int'(irq_o), 1);
        en_pulse(1'b1, 1'b1);
        check("R9 set wins", int'(irq_o), 1);
        en_pulse(1'b0, 1'b1);
        check("R9 clear", int'(irq_o), 0);
        en_pulse(1'b1, 1'b0);
        ack(1);
    endtask

    task automatic t_load();
        num_thresh_i = 6'd20;
        cnt_we_i = 1'b1; cnt_wdata_i = 6'd5;
        cpl_valid_i = 1'b1; cpl_notify_i = 1'b1; ack_we_i = 1'b1; ack_amt_i = 6'd1;
        step(1);
        cnt_we_i = 1'b0; cnt_wdata_i = '0;
        cpl_valid_i = 1'b0; cpl_notify_i = 1'b0; ack_we_i = 1'b0; ack_amt_i = '0;
        check("R11 load priority", int'(pend_cnt_o), 5);
        load(0);
        check("R11 load zero", int'(pend_cnt_o), 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_count_threshold();
        t_num_zero();
        t_same_cycle();
        t_partial_ack();
        t_timer();
        t_saturate();
        t_enable();
        t_load();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule